// File: doc/BRIEF.md
# DMA Fragment/Block/Transaction Sequencer

This block is the address and length engine of one DMA channel. A transfer (the transaction) is cut into blocks, and each block is cut into fragments. Every beat moves one data unit from a source address to a destination address through a simple memory port. The port holds its read and write strobes until the memory acknowledges the beat. After each beat, both addresses advance by their own step. Pulses mark the end of each fragment, block and transaction.

Software programs the lengths, widths, steps and base addresses, enables the channel and raises a one-cycle request. The programmed request mode sets how much one request moves: a fragment, a block or the whole transaction. After that unit the channel waits for the next request and continues from where it stopped. A hold request freezes the channel at a beat boundary, and a status output confirms the freeze.

Top module: `dma_seq`

## Requirements
- R1: After reset, both strobes, `hold_sts`, all done pulses and `cfg_err` are low, and both addresses are zero.
- R2: A `kick` is accepted only when `chan_en` is high and the channel is waiting. Once accepted, the strobes rise on the next cycle and stay high until `beat_ack`. A `kick` while disabled or busy has no effect.
- R3: The first beat of a transaction uses `src_base` and `dst_base`. Each acknowledged beat adds `step_word[15:0]` to the source address and `step_word[31:16]` to the destination address, as unsigned values modulo 2^32.
- R4: `xfer_word[20]` set with `xfer_word[21]`=1 keeps the destination address fixed. `xfer_word[20]` set with `xfer_word[21]`=0 keeps the source address fixed.
- R5: `src_width` equals `xfer_word[31:30]` and `dst_width` equals `xfer_word[29:28]`, where 0 is byte, 1 is halfword and 2 is word. Each beat counts 2^`xfer_word[31:30]` bytes against the lengths.
- R6: The fragment length (`xfer_word[16:0]`), `blk_len` and `trsc_len` are all in bytes. A beat whose bytes reach the end of a fragment, block or transaction pulses the matching done output for one cycle, on the cycle after its acknowledge. The end of a block also ends its fragment, and the end of the transaction also ends its block.
- R7: `xfer_word[25:24]` selects the unit that one request moves: 0 is a fragment, 1 is a block, 2 and 3 are the whole transaction. `unit_done` pulses together with the done pulse of that level. The channel then waits for the next `kick`.
- R8: A `kick` with a zero fragment, block or transaction length pulses `cfg_err` on the next cycle and issues no beat.
- R9: While `hold_req` is high, no new beat is started and a beat in flight finishes. `hold_sts` is high exactly when `hold_req` is high and no beat is strobed. Dropping `hold_req` resumes the beats.
- R10: With `chan_en` low, the strobes are low from the next cycle on. The counters are cleared, and the next accepted `kick` starts a new transaction at the base addresses.
- R11: When a transaction finishes, `dst_addr` and `src_addr` hold their final values until a new transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| kick | input | 1 | Software request, one cycle |
| hold_req | input | 1 | Ask the channel to halt |
| xfer_word | input | 32 | Widths, fix bits, request mode, fragment length |
| blk_len | input | 17 | Block length in bytes |
| trsc_len | input | 28 | Transaction length in bytes |
| step_word | input | 32 | Destination step [31:16], source step [15:0] |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| beat_ack | input | 1 | Memory finished the strobed beat |
| rd_stb | output | 1 | Read strobe for the current beat |
| wr_stb | output | 1 | Write strobe for the current beat |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_width | output | 2 | Source width code |
| dst_width | output | 2 | Destination width code |
| frag_done | output | 1 | Fragment end pulse |
| blk_done | output | 1 | Block end pulse |
| trsc_done | output | 1 | Transaction end pulse |
| unit_done | output | 1 | Requested unit complete pulse |
| cfg_err | output | 1 | Zero-length request pulse |
| hold_sts | output | 1 | Halt confirmed |

## Verification
The assertions assume the following about the inputs:
- The configuration words stay stable from the start of a transaction until it ends or the channel is disabled.
- Every length is a multiple of the beat size.
- The width code is at most 2.
- `beat_ack` is only given while a beat is strobed.

The bench changes configuration only after a transaction has finished or after a disable. It picks lengths that divide evenly by the beat size. It derives `beat_ack` from its own model's view of an active beat, thinned by a programmable period.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int SW_LSB      = 30;
    localparam int DW_LSB      = 28;
    localparam int MODE_LSB    = 24;
    localparam int FIX_SEL_BIT = 21;
    localparam int FIX_EN_BIT  = 20;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_FRAG = 2'd0,
        MODE_BLK  = 2'd1,
        MODE_TRSC = 2'd2,
        MODE_LIST = 2'd3
    } req_mode_e;
endpackage

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
    parameter int FRAG_W = 17,
    parameter int BLK_W  = 17,
    parameter int TRSC_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [3:0]        beat_bytes,
    input  logic [FRAG_W-1:0] frag_len,
    input  logic [BLK_W-1:0]  blk_len,
    input  logic [TRSC_W-1:0] trsc_len,
    output logic              frag_end,
    output logic              blk_end,
    output logic              trsc_end
);
    localparam int FS = FRAG_W + 1;
    localparam int BS = BLK_W + 1;
    localparam int TS = TRSC_W + 1;

    typedef struct packed {
        logic [FRAG_W-1:0] frag;
        logic [BLK_W-1:0]  blk;
        logic [TRSC_W-1:0] trsc;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [FS-1:0] frag_sum;
    logic [BS-1:0] blk_sum;
    logic [TS-1:0] trsc_sum;

    always_comb begin
        frag_sum = {1'b0, cnt_q.frag} + FS'(beat_bytes);
        blk_sum  = {1'b0, cnt_q.blk} + BS'(beat_bytes);
        trsc_sum = {1'b0, cnt_q.trsc} + TS'(beat_bytes);
        trsc_end = trsc_sum >= {1'b0, trsc_len};
        blk_end  = trsc_end || (blk_sum >= {1'b0, blk_len});
        frag_end = blk_end || (frag_sum >= {1'b0, frag_len});
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d.frag = frag_end ? '0 : frag_sum[FRAG_W-1:0];
            cnt_d.blk  = blk_end  ? '0 : blk_sum[BLK_W-1:0];
            cnt_d.trsc = trsc_end ? '0 : trsc_sum[TRSC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    frag_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_len != '0) |-> (cnt_q.frag < frag_len));
    // R6
    blk_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_len != '0) |-> (cnt_q.blk < blk_len));
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              fix_en,
    input  logic              fix_sel,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [STEP_W-1:0] src_step,
    input  logic [STEP_W-1:0] dst_step,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } addr_t;

    addr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.src = src_base;
            a_d.dst = dst_base;
        end else if (adv) begin
            if (!(fix_en && !fix_sel)) a_d.src = a_q.src + ADDR_W'(src_step);
            if (!(fix_en && fix_sel))  a_d.dst = a_q.dst + ADDR_W'(dst_step);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign src_addr = a_q.src;
    assign dst_addr = a_q.dst;

    // R4
    dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && fix_en && fix_sel) |=> $stable(dst_addr));
    // R4
    src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && fix_en && !fix_sel) |=> $stable(src_addr));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int FRAG_W = 17,
    parameter int BLK_W  = 17,
    parameter int TRSC_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              kick,
    input  logic              hold_req,
    input  logic [31:0]       xfer_word,
    input  logic [BLK_W-1:0]  blk_len,
    input  logic [TRSC_W-1:0] trsc_len,
    input  logic [2*STEP_W-1:0] step_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              beat_ack,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [1:0]        src_width,
    output logic [1:0]        dst_width,
    output logic              frag_done,
    output logic              blk_done,
    output logic              trsc_done,
    output logic              unit_done,
    output logic              cfg_err,
    output logic              hold_sts
);
    typedef struct packed {
        seq_state_e st;
        logic       fresh;
        logic       frag_p;
        logic       blk_p;
        logic       trsc_p;
        logic       unit_p;
        logic       err_p;
    } seq_t;

    seq_t s_d, s_q;
    logic load, clear, adv, unit_end, bad_len;
    logic frag_end, blk_end, trsc_end;
    logic [FRAG_W-1:0] frag_len;
    logic [3:0] beat_bytes;
    req_mode_e mode;

    assign frag_len   = xfer_word[FRAG_W-1:0];
    assign mode       = req_mode_e'(xfer_word[MODE_LSB+1:MODE_LSB]);
    assign src_width  = xfer_word[SW_LSB+1:SW_LSB];
    assign dst_width  = xfer_word[DW_LSB+1:DW_LSB];
    assign beat_bytes = 4'd1 << src_width;
    assign bad_len    = (frag_len == '0) || (blk_len == '0) || (trsc_len == '0);

    always_comb begin
        case (mode)
            MODE_FRAG: unit_end = frag_end;
            MODE_BLK:  unit_end = blk_end;
            default:   unit_end = trsc_end;
        endcase
        s_d = s_q;
        s_d.frag_p = 1'b0;
        s_d.blk_p  = 1'b0;
        s_d.trsc_p = 1'b0;
        s_d.unit_p = 1'b0;
        s_d.err_p  = 1'b0;
        load  = 1'b0;
        clear = 1'b0;
        adv   = 1'b0;
        if (!chan_en) begin
            s_d.st    = ST_WAIT;
            s_d.fresh = 1'b1;
            clear     = 1'b1;
        end else begin
            case (s_q.st)
                ST_WAIT: if (kick) begin
                    if (bad_len) begin
                        s_d.err_p = 1'b1;
                    end else begin
                        if (s_q.fresh) begin
                            load      = 1'b1;
                            clear     = 1'b1;
                            s_d.fresh = 1'b0;
                        end
                        s_d.st = hold_req ? ST_HALT : ST_RUN;
                    end
                end
                ST_RUN: if (beat_ack) begin
                    adv        = 1'b1;
                    s_d.frag_p = frag_end;
                    s_d.blk_p  = blk_end;
                    s_d.trsc_p = trsc_end;
                    if (trsc_end) s_d.fresh = 1'b1;
                    if (unit_end) begin
                        s_d.unit_p = 1'b1;
                        s_d.st     = ST_WAIT;
                    end else if (hold_req) begin
                        s_d.st = ST_HALT;
                    end
                end
                ST_HALT: if (!hold_req) s_d.st = ST_RUN;
                default: s_d.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_WAIT;
            s_q.fresh <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    dma_seq_count #(.FRAG_W(FRAG_W), .BLK_W(BLK_W), .TRSC_W(TRSC_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clear(clear), .adv(adv),
        .beat_bytes(beat_bytes), .frag_len(frag_len), .blk_len(blk_len),
        .trsc_len(trsc_len), .frag_end(frag_end), .blk_end(blk_end),
        .trsc_end(trsc_end)
    );

    dma_seq_addr #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .fix_en(xfer_word[FIX_EN_BIT]), .fix_sel(xfer_word[FIX_SEL_BIT]),
        .src_base(src_base), .dst_base(dst_base),
        .src_step(step_word[STEP_W-1:0]), .dst_step(step_word[2*STEP_W-1:STEP_W]),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    assign rd_stb    = (s_q.st == ST_RUN);
    assign wr_stb    = (s_q.st == ST_RUN);
    assign hold_sts  = hold_req && (s_q.st != ST_RUN);
    assign frag_done = s_q.frag_p;
    assign blk_done  = s_q.blk_p;
    assign trsc_done = s_q.trsc_p;
    assign unit_done = s_q.unit_p;
    assign cfg_err   = s_q.err_p;

    // R2
    stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !beat_ack && chan_en) |=> rd_stb);
    // R10
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !rd_stb);
    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !rd_stb);
    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_req) && hold_req && !$past(rd_stb)) |-> !rd_stb);
    // R7
    unit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |-> !rd_stb);
endmodule

// File: tb/dma_seq_bench.sv
`timescale 1ns/1ps
module dma_seq_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, chan_en = 1'b0, kick = 1'b0, hold_req = 1'b0, beat_ack = 1'b0;
    logic [31:0] xfer_word = '0, step_word = '0, src_base = '0, dst_base = '0;
    logic [16:0] blk_len = '0;
    logic [27:0] trsc_len = '0;
    logic rd_stb, wr_stb, frag_done, blk_done, trsc_done, unit_done, cfg_err, hold_sts;
    logic [31:0] src_addr, dst_addr;
    logic [1:0] src_width, dst_width;

    dma_seq u_dma_seq (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .kick(kick), .hold_req(hold_req),
        .xfer_word(xfer_word), .blk_len(blk_len), .trsc_len(trsc_len),
        .step_word(step_word), .src_base(src_base), .dst_base(dst_base),
        .beat_ack(beat_ack), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_width(src_width),
        .dst_width(dst_width), .frag_done(frag_done), .blk_done(blk_done),
        .trsc_done(trsc_done), .unit_done(unit_done), .cfg_err(cfg_err),
        .hold_sts(hold_sts)
    );

    int errs = 0, checks = 0, cyc = 0, ack_per = 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state: 0 waiting, 1 beat active, 2 halted
    int mst = 0, fc = 0, bc = 0, tc = 0;
    bit fresh = 1'b1;
    bit [31:0] sa = '0, da = '0;
    bit pf, pb, pt, pu, pe;

    always @(posedge clk) begin : model
        int by, fl, bl, tl, md;
        bit fe, be, te, fin;
        if (!rst_n) begin
            mst = 0; fresh = 1; fc = 0; bc = 0; tc = 0; sa = '0; da = '0;
            pf = 0; pb = 0; pt = 0; pu = 0; pe = 0;
        end else begin
            pf = 0; pb = 0; pt = 0; pu = 0; pe = 0;
            by = 1 << xfer_word[31:30];
            fl = int'(xfer_word[16:0]);
            bl = int'(blk_len);
            tl = int'(trsc_len);
            md = int'(xfer_word[25:24]);
            if (!chan_en) begin
                mst = 0; fresh = 1; fc = 0; bc = 0; tc = 0;
            end else if (mst == 0) begin
                if (kick) begin
                    if (fl == 0 || bl == 0 || tl == 0) pe = 1;
                    else begin
                        if (fresh) begin
                            sa = src_base; da = dst_base; fc = 0; bc = 0; tc = 0; fresh = 0;
                        end
                        mst = hold_req ? 2 : 1;
                    end
                end
            end else if (mst == 1) begin
                if (beat_ack) begin
                    te = (tc + by >= tl);
                    be = te || (bc + by >= bl);
                    fe = be || (fc + by >= fl);
                    tc = te ? 0 : tc + by;
                    bc = be ? 0 : bc + by;
                    fc = fe ? 0 : fc + by;
                    if (!(xfer_word[20] && !xfer_word[21])) sa = sa + 32'(step_word[15:0]);
                    if (!(xfer_word[20] && xfer_word[21]))  da = da + 32'(step_word[31:16]);
                    pf = fe; pb = be; pt = te;
                    if (te) fresh = 1;
                    fin = (md == 0) ? fe : (md == 1) ? be : te;
                    if (fin) begin pu = 1; mst = 0; end
                    else if (hold_req) mst = 2;
                end
            end else if (!hold_req) begin
                mst = 1;
            end
        end
        #2;
        chk("R2 rd_stb", 32'(rd_stb), 32'(mst == 1));
        chk("R2 wr_stb", 32'(wr_stb), 32'(mst == 1));
        chk("R9 hold_sts", 32'(hold_sts), 32'(hold_req && mst != 1));
        chk("R3 src_addr", src_addr, sa);
        chk("R3 dst_addr", dst_addr, da);
        chk("R6 frag_done", 32'(frag_done), 32'(pf));
        chk("R6 blk_done", 32'(blk_done), 32'(pb));
        chk("R6 trsc_done", 32'(trsc_done), 32'(pt));
        chk("R7 unit_done", 32'(unit_done), 32'(pu));
        chk("R8 cfg_err", 32'(cfg_err), 32'(pe));
        chk("R5 widths", {28'd0, src_width, dst_width}, {28'd0, xfer_word[31:28]});
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        beat_ack = (mst == 1) && ((cyc % ack_per) == 0);
    end

    task automatic setup(int mode, int w, int frag, int blk, int trsc,
                         int sst, int dst, bit fen, bit fsel);
        @(negedge clk);
        xfer_word = {w[1:0], w[1:0], 2'b00, mode[1:0], 2'b00, fsel, fen, 3'b000, frag[16:0]};
        blk_len   = blk[16:0];
        trsc_len  = trsc[27:0];
        step_word = {dst[15:0], sst[15:0]};
    endtask

    task automatic do_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        chk("R1 reset strobe", 32'(rd_stb), 32'd0);
        chk("R1 reset dst", dst_addr, 32'd0);
        chk("R1 reset hold_sts", 32'(hold_sts), 32'd0);
        rst_n = 1'b1;
        src_base = 32'h1000; dst_base = 32'h2000;
        // R2: kick while disabled is ignored
        setup(1, 2, 8, 16, 32, 4, 4, 0, 0);
        do_kick(); wait_n(4);
        chk("R2 disabled kick", 32'(rd_stb), 32'd0);
        // R7 block mode, then R11 retained address
        chan_en = 1'b1;
        do_kick(); wait_n(20);
        chk("R7 block unit dst", dst_addr, 32'h2010);
        do_kick(); wait_n(20);
        chk("R11 final dst", dst_addr, 32'h2020);
        wait_n(5);
        chk("R11 dst held", dst_addr, 32'h2020);
        chk("R11 src held", src_addr, 32'h1020);
        // fragment mode, halfword, slow memory
        ack_per = 3;
        setup(0, 1, 4, 8, 16, 2, 2, 0, 0);
        for (int i = 0; i < 4; i++) begin do_kick(); wait_n(30); end
        chk("R7 fragment units dst", dst_addr, 32'h2010);
        // R4 destination fixed, byte width, odd lengths
        ack_per = 2;
        setup(2, 0, 3, 5, 9, 1, 1, 1, 1);
        do_kick(); wait_n(40);
        chk("R4 dst fixed", dst_addr, 32'h2000);
        chk("R4 src moved", src_addr, 32'h1009);
        // R4 source fixed, mode 3 acts as a transaction
        setup(3, 0, 3, 5, 9, 1, 1, 1, 0);
        do_kick(); wait_n(40);
        chk("R4 src fixed", src_addr, 32'h1000);
        chk("R7 list mode dst", dst_addr, 32'h2009);
        // R8 zero block length
        setup(2, 2, 8, 0, 32, 4, 4, 0, 0);
        do_kick(); wait_n(3);
        chk("R8 no beat", 32'(rd_stb), 32'd0);
        // R9 halt and resume
        setup(2, 2, 8, 16, 64, 4, 4, 0, 0);
        do_kick(); wait_n(5);
        hold_req = 1'b1; wait_n(10);
        chk("R9 halted status", 32'(hold_sts), 32'd1);
        chk("R9 halted strobe", 32'(rd_stb), 32'd0);
        hold_req = 1'b0; wait_n(60);
        chk("R9 resumed to end", dst_addr, 32'h2040);
        // R10 disable mid-transfer, then restart at base
        ack_per = 1;
        do_kick(); wait_n(6);
        chan_en = 1'b0; wait_n(2);
        chk("R10 disabled strobe", 32'(rd_stb), 32'd0);
        chan_en = 1'b1;
        do_kick();
        chk("R10 restart src", src_addr, 32'h1000);
        chk("R10 restart dst", dst_addr, 32'h2000);
        wait_n(80);
        chk("R10 full run after restart", dst_addr, 32'h2040);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule